// File: doc/BRIEF.md
# Global Intensity Subframe Distributor

This block sits beside an LED driver's PWM engine and decides, for every subframe of a video frame, whether that subframe may light the outputs at all. A global intensity value N selects how many of the M subframes in a frame are enabled. The enabled subframes are scattered as evenly as the ratio allows rather than bunched at the start of the frame, which keeps the visible refresh rate high even at reduced brightness.

Two resolutions are supported. In the long mode a frame has 128 subframes; in the short mode it has 32. In the short mode a fast-refresh option shortens the spreading period to a quarter of the frame: the pattern then repeats four times per frame using a quarter of the intensity value, so flicker drops at the cost of coarser global steps. An upstream timer supplies one strobe per subframe boundary; the block answers with the enable for the subframe just opened, its index, and a pulse marking the first subframe of each frame. The intensity value and both mode bits are captured only when a frame opens.

Top module: `gi_subframe_spreader`

## Requirements
- R1: While reset is held and after its release, until the first strobe, `sf_enable`, `sf_index` and `frame_start` are 0.
- R2: Each cycle with `sf_tick` high opens the next subframe; the outputs update on the clock edge where the strobe is sampled and hold steady in every other cycle. `sf_index` counts 0 up to L-1 and then returns to 0, where L is 128 when `res_hi` is 0 and 32 when `res_hi` is 1.
- R3: The first strobe after reset and every strobe that follows subframe L-1 open subframe 0; `frame_start` is high for exactly the one cycle after that edge and low otherwise.
- R4: Outside fast refresh, a frame with value N enables exactly min(N, L) subframes.
- R5: With period length P and effective value n, the subframe at position j within its period (j = index mod P) is enabled exactly when floor((j+1)*n/P) is greater than floor(j*n/P).
- R6: A value of 0 leaves every subframe disabled; a value of L or above enables every subframe (values above L are treated as L).
- R7: With `res_hi` = 1 and `fast_refresh` = 1 the period is P = 8 and n = min(N,32) divided by 4 rounded down, so the pattern repeats every 8 subframes and a frame enables 4*n subframes; the two low bits of N have no effect.
- R8: With `res_hi` = 0 the `fast_refresh` input has no effect: P = 128 and n = min(N,128).
- R9: `gi_value`, `res_hi` and `fast_refresh` are sampled only by the strobe that opens subframe 0; changes during a frame affect neither that frame's enables nor its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_tick | input | 1 | One-cycle strobe at each subframe boundary |
| gi_value | input | 8 | Global intensity value N (0 to 128; larger values clamp) |
| res_hi | input | 1 | 0: 128 subframes per frame, 1: 32 subframes per frame |
| fast_refresh | input | 1 | Quarter-length spreading period, honoured only when res_hi is 1 |
| sf_enable | output | 1 | Output enable for the current subframe |
| sf_index | output | 7 | Index of the current subframe within the frame |
| frame_start | output | 1 | One-cycle pulse when subframe 0 opens |

## Verification
The spreading rule is tried with values that divide the period exactly (32 of 128, full scale), with values coprime to it (1 of 128, 5 of 32) and with the 96-of-128 case, so that a wrong carry test, an off-by-one in the wrap or a packed rather than scattered pattern shows up in the per-subframe comparison and not only in the total. Out-of-range values distinguish clamping from wrap-around, and fast-refresh vectors with values that are not multiples of four tell a correct quarter-value from one that keeps the low bits; the same value with fast refresh in long mode shows the bit is ignored there. A frame whose inputs change after its first subframe separates frame-boundary capture from live sampling.

// File: rtl/gisd_pkg.sv
package gisd_pkg;

  typedef struct packed {
    logic hi_res;
    logic fast;
  } gi_mode_t;

  // Subframes in one frame for a given mode.
  function automatic int unsigned frame_len(gi_mode_t m, int unsigned long_sf,
                                            int unsigned short_sf);
    return m.hi_res ? short_sf : long_sf;
  endfunction

  // Length of the spreading period (the accumulator modulus).
  function automatic int unsigned period_len(gi_mode_t m, int unsigned long_sf,
                                             int unsigned short_sf, int unsigned fast_div);
    if (!m.hi_res) return long_sf;
    return m.fast ? short_sf / fast_div : short_sf;
  endfunction

  // Raw intensity clamped to the frame length, then scaled for fast refresh.
  function automatic int unsigned eff_value(int unsigned raw, gi_mode_t m,
                                            int unsigned long_sf, int unsigned short_sf,
                                            int unsigned fast_div);
    int unsigned lim;
    int unsigned v;
    lim = frame_len(m, long_sf, short_sf);
    v   = (raw > lim) ? lim : raw;
    if (m.hi_res && m.fast) v = v / fast_div;
    return v;
  endfunction

  // Spreading step: a subframe is enabled when the running sum reaches the modulus.
  function automatic logic spread_carry(int unsigned acc, int unsigned val, int unsigned modulus);
    return (acc + val) >= modulus;
  endfunction

  function automatic int unsigned spread_next(int unsigned acc, int unsigned val,
                                              int unsigned modulus);
    int unsigned s;
    s = acc + val;
    return (s >= modulus) ? s - modulus : s;
  endfunction

endpackage

// File: rtl/gisd_frame_seq.sv
module gisd_frame_seq #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [IDX_W-1:0] last_idx,
  output logic             new_frame,
  output logic [IDX_W-1:0] idx_q,
  output logic             frame_start_q
);

  logic run_q;

  assign new_frame = tick && (!run_q || (idx_q == last_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q         <= 1'b0;
      idx_q         <= '0;
      frame_start_q <= 1'b0;
    end else begin
      frame_start_q <= new_frame;
      if (tick) begin
        run_q <= 1'b1;
        idx_q <= new_frame ? '0 : idx_q + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/gisd_spread_acc.sv
module gisd_spread_acc import gisd_pkg::*; #(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [VAL_W-1:0] step_val,
  input  logic [VAL_W-1:0] step_mod,
  output logic             carry,
  output logic             en_q,
  output logic [VAL_W-1:0] acc_q
);

  logic [VAL_W-1:0] acc_base;
  logic [VAL_W-1:0] acc_nxt;

  assign acc_base = restart ? '0 : acc_q;
  assign carry    = spread_carry(32'(acc_base), 32'(step_val), 32'(step_mod));
  assign acc_nxt  = VAL_W'(spread_next(32'(acc_base), 32'(step_val), 32'(step_mod)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else if (tick) begin
      acc_q <= acc_nxt;
      en_q  <= carry;
    end
  end

endmodule

// File: rtl/gi_subframe_spreader.sv
module gi_subframe_spreader import gisd_pkg::*; #(
  parameter int unsigned LONG_SF  = 128,
  parameter int unsigned SHORT_SF = 32,
  parameter int unsigned FAST_DIV = 4,
  localparam int unsigned VAL_W   = $clog2(LONG_SF + 1),
  localparam int unsigned IDX_W   = $clog2(LONG_SF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_tick,
  input  logic [VAL_W-1:0] gi_value,
  input  logic             res_hi,
  input  logic             fast_refresh,
  output logic             sf_enable,
  output logic [IDX_W-1:0] sf_index,
  output logic             frame_start
);

  gi_mode_t         mode_in, mode_q;
  logic             new_frame;
  logic             step_carry;
  logic [IDX_W-1:0] last_idx;
  logic [VAL_W-1:0] val_in, val_q, mod_in, mod_q;
  logic [VAL_W-1:0] step_val, step_mod, acc_q;

  assign mode_in  = '{hi_res: res_hi, fast: fast_refresh};
  assign val_in   = VAL_W'(eff_value(32'(gi_value), mode_in, LONG_SF, SHORT_SF, FAST_DIV));
  assign mod_in   = VAL_W'(period_len(mode_in, LONG_SF, SHORT_SF, FAST_DIV));
  assign last_idx = IDX_W'(frame_len(mode_q, LONG_SF, SHORT_SF) - 1);

  // Frame settings are captured only when subframe 0 opens.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      val_q  <= '0;
      mod_q  <= VAL_W'(LONG_SF);
    end else if (new_frame) begin
      mode_q <= mode_in;
      val_q  <= val_in;
      mod_q  <= mod_in;
    end
  end

  assign step_val = new_frame ? val_in : val_q;
  assign step_mod = new_frame ? mod_in : mod_q;

  gisd_frame_seq #(.IDX_W(IDX_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (sf_tick),
    .last_idx      (last_idx),
    .new_frame     (new_frame),
    .idx_q         (sf_index),
    .frame_start_q (frame_start)
  );

  gisd_spread_acc #(.VAL_W(VAL_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sf_tick),
    .restart  (new_frame),
    .step_val (step_val),
    .step_mod (step_mod),
    .carry    (step_carry),
    .en_q     (sf_enable),
    .acc_q    (acc_q)
  );

endmodule

// File: rtl/gi_subframe_spreader_chk.sv
module gi_subframe_spreader_chk #(
  parameter int unsigned LONG_SF  = 128,
  parameter int unsigned SHORT_SF = 32,
  parameter int unsigned VAL_W    = 8,
  parameter int unsigned IDX_W    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sf_tick,
  input logic [VAL_W-1:0] gi_value,
  input logic             res_hi,
  input logic             sf_enable,
  input logic [IDX_W-1:0] sf_index,
  input logic             frame_start,
  input logic             new_frame,
  input logic [IDX_W-1:0] last_idx,
  input logic [VAL_W-1:0] acc_q,
  input logic [VAL_W-1:0] mod_q
);

  AST_FS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (sf_index == '0)); // R3

  AST_FS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_tick |=> ($stable(sf_index) && $stable(sf_enable))); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_tick && !new_frame) |=> (sf_index == IDX_W'($past(sf_index) + 1'b1))); // R2

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sf_index <= last_idx); // R2

  AST_ZERO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (new_frame && gi_value == '0) |=> !sf_enable); // R6

  AST_FULL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (new_frame && (32'(gi_value) >= (res_hi ? SHORT_SF : LONG_SF))) |=> sf_enable); // R6

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < mod_q); // R5

endmodule

bind gi_subframe_spreader gi_subframe_spreader_chk #(
  .LONG_SF  (LONG_SF),
  .SHORT_SF (SHORT_SF),
  .VAL_W    (VAL_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sf_tick     (sf_tick),
  .gi_value    (gi_value),
  .res_hi      (res_hi),
  .sf_enable   (sf_enable),
  .sf_index    (sf_index),
  .frame_start (frame_start),
  .new_frame   (new_frame),
  .last_idx    (last_idx),
  .acc_q       (acc_q),
  .mod_q       (mod_q)
);

// File: tb/gi_subframe_spreader_tb.sv
module gi_subframe_spreader_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sf_tick;
  logic [7:0] gi_value;
  logic       res_hi;
  logic       fast_refresh;
  logic       sf_enable;
  logic [6:0] sf_index;
  logic       frame_start;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gi_subframe_spreader u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sf_tick      (sf_tick),
    .gi_value     (gi_value),
    .res_hi       (res_hi),
    .fast_refresh (fast_refresh),
    .sf_enable    (sf_enable),
    .sf_index     (sf_index),
    .frame_start  (frame_start)
  );

  typedef struct packed {
    logic       res;
    logic       fast;
    logic [7:0] val;
    logic [7:0] cnt;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd96,  8'd96},   // R4 R5 uneven ratio
    '{1'b0, 1'b0, 8'd0,   8'd0},    // R6 none
    '{1'b0, 1'b0, 8'd128, 8'd128},  // R6 full
    '{1'b0, 1'b0, 8'd1,   8'd1},    // R5 single
    '{1'b0, 1'b0, 8'd32,  8'd32},   // R5 exact divisor
    '{1'b0, 1'b0, 8'd200, 8'd128},  // R6 clamp
    '{1'b1, 1'b0, 8'd32,  8'd32},   // R2 short frame
    '{1'b1, 1'b0, 8'd5,   8'd5},    // R4 coprime
    '{1'b1, 1'b0, 8'd40,  8'd32},   // R6 clamp short
    '{1'b1, 1'b1, 8'd32,  8'd32},   // R7 full fast
    '{1'b1, 1'b1, 8'd12,  8'd12},   // R7
    '{1'b1, 1'b1, 8'd7,   8'd4},    // R7 low bits dropped
    '{1'b0, 1'b1, 8'd64,  8'd64}    // R8 fast ignored
  };

  function automatic bit exp_en(int k, int res, int fast, int val);
    int m, n, j;
    n = (val > (res ? 32 : 128)) ? (res ? 32 : 128) : val;
    m = res ? 32 : 128;
    if (res && fast) begin
      m = 8;
      n = n / 4;
    end
    j = k % m;
    return ((j + 1) * n) / m > (j * n) / m;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    sf_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) sf_tick = 1'b1;
    @(negedge clk) sf_tick = 1'b0;
  endtask

  // Runs one frame of len subframes and checks index, frame pulse and pattern.
  task automatic run_frame(int len, int res, int fast, int val, output int cnt);
    int bad_idx = 0;
    int bad_fs  = 0;
    int bad_pat = 0;
    cnt = 0;
    for (int k = 0; k < len; k++) begin
      do_tick();
      if (sf_index != 7'(k)) bad_idx++;
      if (frame_start != (k == 0)) bad_fs++;
      if (sf_enable != exp_en(k, res, fast, val)) bad_pat++;
      if (sf_enable) cnt++;
    end
    check(bad_idx == 0, "R2 index sequence", bad_idx, 0);
    check(bad_fs == 0, "R3 frame_start pulse", bad_fs, 0);
    check(bad_pat == 0, "R5 spread pattern", bad_pat, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    gi_value = 8'd0; res_hi = 1'b0; fast_refresh = 1'b0;

    // R1 reset state
    rst_n = 1'b0; sf_tick = 1'b0;
    repeat (2) @(negedge clk);
    check(sf_enable == 0 && sf_index == 0 && frame_start == 0, "R1 during reset",
          int'({sf_enable, sf_index, frame_start}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sf_enable == 0 && sf_index == 0 && frame_start == 0, "R1 after release",
          int'({sf_enable, sf_index, frame_start}), 0);

    // Vector table: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      do_reset();
      gi_value = VECS[v].val; res_hi = VECS[v].res; fast_refresh = VECS[v].fast;
      run_frame(VECS[v].res ? 32 : 128, VECS[v].res, VECS[v].fast, VECS[v].val, cnt);
      check(cnt == int'(VECS[v].cnt), "R4 R6 R7 R8 enabled count", cnt, VECS[v].cnt);
    end

    // R2 outputs hold between strobes; wrap back to subframe 0
    do_reset();
    gi_value = 8'd5; res_hi = 1'b1; fast_refresh = 1'b0;
    run_frame(32, 1, 0, 5, cnt);
    begin
      logic [7:0] snap;
      snap = {sf_enable, sf_index};
      repeat (6) @(negedge clk);
      check({sf_enable, sf_index} == snap, "R2 hold without strobe",
            int'({sf_enable, sf_index}), int'(snap));
    end
    do_tick();
    check(sf_index == 0 && frame_start == 1, "R3 wrap opens subframe 0",
          int'({sf_index, frame_start}), 1);

    // R9 mid-frame changes are ignored until the next frame
    do_reset();
    gi_value = 8'd96; res_hi = 1'b0; fast_refresh = 1'b0;
    cnt = 0;
    begin
      int bad = 0;
      for (int k = 0; k < 128; k++) begin
        do_tick();
        if (k == 0) begin
          gi_value = 8'd0; res_hi = 1'b1; fast_refresh = 1'b1;
        end
        if (sf_index != 7'(k) || sf_enable != exp_en(k, 0, 0, 96)) bad++;
        if (sf_enable) cnt++;
      end
      check(bad == 0, "R9 frame kept length and pattern", bad, 0);
      check(cnt == 96, "R9 frame kept value", cnt, 96);
    end
    run_frame(32, 1, 1, 0, cnt);
    check(cnt == 0, "R9 new settings in next frame", cnt, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule